// File: doc/BRIEF.md
# Masked Change Detection and Pattern Trigger

This block watches a parallel input word that is not synchronous to the block clock. A significance mask chooses which bits matter. When any of those bits changes while an acquisition is running, the block records the whole word. This includes the bits outside the mask. It then pulses a capture strobe for one clock. The block holds only the last captured word; whatever consumes the strobe has to take the word before the next one arrives.

An acquisition is framed by a start event and a stop event. Each event is chosen from a few sources: an immediate start on arming, an edge on a dedicated pin with a selectable direction, or a pattern event. The pattern event compares the masked bits of the input word against a compare word. It can fire on equality or on inequality, and it fires only at the transition into the selected condition. The mask used for the comparison is the same mask that governs change detection. A stop that asks the block to finish before a minimum number of words has been captured ends the acquisition in a fault state instead.

The controller has six states. From IDLE, raising `go` moves it to ARMED. ARMED moves to SYNC on the start event. SYNC always moves to RUN one clock later. RUN moves to DONE on a stop event once at least `pre_cnt` words have been captured, and to FAULT on a stop event before that. DONE and FAULT hold. Dropping `go` returns any state to IDLE.

Top module: `chgdet_trig`

## Requirements
- R1: A change on a masked bit of `port_in` while the controller is in RUN gives one `cap_stb` pulse exactly three clocks after the clock edge at which the change arrives. The three clocks are two synchroniser stages and one capture register.
- R2: A change that touches only bits where `sig_mask` is 0 produces no capture.
- R3: `cap_data` holds the full synchronised input word, including unmasked bits, from the capture until the next capture.
- R4: No capture occurs in IDLE, ARMED, SYNC, DONE or FAULT.
- R5: The trigger source encodings are the same for start and stop. 0 starts immediately once armed; as a stop source, 0 never fires. 1 is the edge pin, rising when its `*_fall` input is 0 and falling when it is 1. 2 is the pattern event. 3 never fires. `start_evt` pulses once when the start is taken.
- R6: The pattern compare uses only bits where `sig_mask` is 1. With `pat_on_miss`=0 the condition is masked equality with `cmp_pat`; with `pat_on_miss`=1 it is masked inequality.
- R7: A pattern event fires only in the clock where the condition becomes true. Holding the condition true fires nothing more.
- R8: After the start event the controller spends one clock in SYNC. A masked change that becomes visible in that clock is not captured; the next one is.
- R9: A stop event that arrives before the start is ignored. `stop_evt` stays low, and `done` and `err_early` stay low.
- R10: A stop event in RUN with at least `pre_cnt` captures taken enters DONE (`done`=1, `active`=0). No further captures follow.
- R11: A stop event in RUN with fewer than `pre_cnt` captures enters FAULT (`err_early`=1). FAULT holds while `go` stays high.
- R12: `go`=0 returns the controller to IDLE within one clock. This clears `active`, `done` and `err_early`.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | W | Monitored input word (asynchronous) |
| sig_mask | input | W | Significant-bit mask for change detection and pattern compare |
| cmp_pat | input | W | Compare word for the pattern trigger |
| pat_on_miss | input | 1 | 0: pattern fires on masked match, 1: on masked mismatch |
| start_sel | input | 2 | Start source (0 immediate, 1 edge pin, 2 pattern, 3 never) |
| stop_sel | input | 2 | Stop source (0 never, 1 edge pin, 2 pattern, 3 never) |
| start_pin | input | 1 | Start edge trigger input (asynchronous) |
| start_fall | input | 1 | 1 selects the falling edge of `start_pin` |
| stop_pin | input | 1 | Stop edge trigger input (asynchronous) |
| stop_fall | input | 1 | 1 selects the falling edge of `stop_pin` |
| pre_cnt | input | CNT_W | Minimum number of captures before a stop is accepted |
| go | input | 1 | Arm request; low returns to IDLE |
| cap_stb | output | 1 | One-clock capture strobe |
| cap_data | output | W | Last captured word |
| start_evt | output | 1 | Pulse when the start is taken |
| stop_evt | output | 1 | Pulse when a stop is taken in RUN |
| active | output | 1 | Controller is in RUN |
| done | output | 1 | Controller is in DONE |
| err_early | output | 1 | Controller is in FAULT |

## Verification
The properties assume that the configuration inputs (`sig_mask`, `cmp_pat`, `pat_on_miss`, the source selects and `pre_cnt`) change only while `go` is low. They also assume that the asynchronous inputs are held long enough to pass the two synchroniser stages. The stimulus follows both rules. It reconfigures only in IDLE, and it holds every port value and edge-pin level for at least four clocks, except for the deliberate back-to-back changes that probe the SYNC clock. The scoreboard expects each capture at a fixed clock count after the change was driven. A missed, extra or late strobe is therefore reported, not only a wrong word.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT = 2'd0,
        SRC_EDGE = 2'd1,
        SRC_PAT  = 2'd2,
        SRC_OFF  = 2'd3
    } trig_src_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_SYNC  = 3'd2,
        ST_RUN   = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } ctrl_state_e;

endpackage

// File: rtl/cdt_sync.sv
// Multi-stage synchroniser followed by one history register.
// cur is the newest synchronised sample, prev the one before it.
module cdt_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int LAST = STAGES;

    logic [W-1:0] chain [LAST+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= LAST; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i <= LAST; i++) chain[i] <= chain[i-1];
        end
    end

    assign cur  = chain[LAST-1];
    assign prev = chain[LAST];
endmodule

// File: rtl/cdt_pattern.sv
// Masked pattern comparison, qualified to the rising edge of the condition.
module cdt_pattern #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pattern,
    input  logic         on_miss,
    output logic         cond,
    output logic         evt
);
    logic hit;
    logic cond_q;

    assign hit  = (((sample ^ pattern) & mask) == '0);
    assign cond = hit ^ on_miss;
    assign evt  = cond & ~cond_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end
endmodule

// File: rtl/cdt_trig_sel.sv
// Selects one trigger source and turns it into a single-clock hit.
module cdt_trig_sel
    import cdt_pkg::*;
(
    input  trig_src_e src,
    input  logic      soft_lvl,
    input  logic      pin_cur,
    input  logic      pin_prev,
    input  logic      fall,
    input  logic      pat_evt,
    output logic      hit
);
    logic edge_hit;

    assign edge_hit = fall ? (pin_prev & ~pin_cur) : (pin_cur & ~pin_prev);

    always_comb begin
        unique case (src)
            SRC_SOFT: hit = soft_lvl;
            SRC_EDGE: hit = edge_hit;
            SRC_PAT:  hit = pat_evt;
            SRC_OFF:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdt_ctrl.sv
// Acquisition controller: state register, next-state logic, registered outputs.
module cdt_ctrl
    import cdt_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             start_hit,
    input  logic             stop_hit,
    input  logic             change_any,
    input  logic [W-1:0]     sample,
    input  logic [CNT_W-1:0] pre_cnt,
    output logic             cap_stb,
    output logic [W-1:0]     cap_data,
    output logic             start_evt,
    output logic             stop_evt,
    output logic             active,
    output logic             done,
    output logic             err_early
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ctrl_state_e       state, state_nx;
    logic [CNT_W-1:0]  cap_cnt;
    logic              take_cap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!go) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_ARMED;
                ST_ARMED: if (start_hit) state_nx = ST_SYNC;
                ST_SYNC:  state_nx = ST_RUN;
                ST_RUN:   if (stop_hit)
                              state_nx = (cap_cnt >= pre_cnt) ? ST_DONE : ST_FAULT;
                ST_DONE:  state_nx = ST_DONE;
                ST_FAULT: state_nx = ST_FAULT;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    assign take_cap = (state == ST_RUN) && change_any;

    // registered outputs and capture counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_stb   <= 1'b0;
            cap_data  <= '0;
            start_evt <= 1'b0;
            stop_evt  <= 1'b0;
            cap_cnt   <= '0;
        end else begin
            cap_stb   <= take_cap;
            start_evt <= (state == ST_ARMED) && go && start_hit;
            stop_evt  <= (state == ST_RUN) && go && stop_hit;
            if (take_cap) cap_data <= sample;
            if (state == ST_ARMED)
                cap_cnt <= '0;
            else if (take_cap && cap_cnt != CNT_MAX)
                cap_cnt <= cap_cnt + 1'b1;
        end
    end

    assign active    = (state == ST_RUN);
    assign done      = (state == ST_DONE);
    assign err_early = (state == ST_FAULT);
endmodule

// File: rtl/chgdet_trig.sv
module chgdet_trig
    import cdt_pkg::*;
#(
    parameter int W      = 32,
    parameter int CNT_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     port_in,
    input  logic [W-1:0]     sig_mask,
    input  logic [W-1:0]     cmp_pat,
    input  logic             pat_on_miss,
    input  logic [1:0]       start_sel,
    input  logic [1:0]       stop_sel,
    input  logic             start_pin,
    input  logic             start_fall,
    input  logic             stop_pin,
    input  logic             stop_fall,
    input  logic [CNT_W-1:0] pre_cnt,
    input  logic             go,
    output logic             cap_stb,
    output logic [W-1:0]     cap_data,
    output logic             start_evt,
    output logic             stop_evt,
    output logic             active,
    output logic             done,
    output logic             err_early
);
    localparam int PIN_W = 2;

    logic [W-1:0]     s_cur, s_prev;
    logic [PIN_W-1:0] p_cur, p_prev;
    logic             pat_cond, pat_evt;
    logic             change_any;
    logic             start_hit, stop_hit;

    cdt_sync #(.W(W), .STAGES(STAGES)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .din(port_in), .cur(s_cur), .prev(s_prev)
    );

    cdt_sync #(.W(PIN_W), .STAGES(STAGES)) u_sync_pins (
        .clk(clk), .rst_n(rst_n), .din({stop_pin, start_pin}),
        .cur(p_cur), .prev(p_prev)
    );

    assign change_any = |((s_cur ^ s_prev) & sig_mask);

    cdt_pattern #(.W(W)) u_pattern (
        .clk(clk), .rst_n(rst_n), .sample(s_cur), .mask(sig_mask),
        .pattern(cmp_pat), .on_miss(pat_on_miss), .cond(pat_cond), .evt(pat_evt)
    );

    cdt_trig_sel u_start_sel (
        .src(trig_src_e'(start_sel)), .soft_lvl(1'b1),
        .pin_cur(p_cur[0]), .pin_prev(p_prev[0]), .fall(start_fall),
        .pat_evt(pat_evt), .hit(start_hit)
    );

    cdt_trig_sel u_stop_sel (
        .src(trig_src_e'(stop_sel)), .soft_lvl(1'b0),
        .pin_cur(p_cur[1]), .pin_prev(p_prev[1]), .fall(stop_fall),
        .pat_evt(pat_evt), .hit(stop_hit)
    );

    cdt_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go),
        .start_hit(start_hit), .stop_hit(stop_hit),
        .change_any(change_any), .sample(s_cur), .pre_cnt(pre_cnt),
        .cap_stb(cap_stb), .cap_data(cap_data),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .active(active), .done(done), .err_early(err_early)
    );

    logic unused_cond;
    assign unused_cond = pat_cond;
endmodule

// File: rtl/chgdet_trig_chk.sv
module chgdet_trig_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         go,
    input logic         cap_stb,
    input logic [W-1:0] cap_data,
    input logic         start_evt,
    input logic         stop_evt,
    input logic         active,
    input logic         done,
    input logic         err_early
);
    AST_CAP_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) cap_stb |-> $past(active)); // R4
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap_stb |-> $stable(cap_data)); // R3
    AST_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n) start_evt |-> !active); // R8
    AST_STOP_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |-> $past(active)); // R9
    AST_DONE_IDLE_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !active); // R10
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err_early)); // R11
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (err_early && go) |=> err_early); // R11
    AST_GO_DROP: assert property (@(posedge clk) disable iff (!rst_n) !go |=> (!active && !done && !err_early)); // R12
endmodule

bind chgdet_trig chgdet_trig_chk #(.W(W)) u_chk (.*);

// File: tb/chgdet_trig_test.sv
module chgdet_trig_test;
    localparam int W  = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  port_in = '0;
    logic [W-1:0]  sig_mask = 32'h0000_FFFF;
    logic [W-1:0]  cmp_pat = '0;
    logic          pat_on_miss = 1'b0;
    logic [1:0]    start_sel = 2'd0;
    logic [1:0]    stop_sel = 2'd3;
    logic          start_pin = 1'b0, start_fall = 1'b0;
    logic          stop_pin = 1'b0, stop_fall = 1'b0;
    logic [CW-1:0] pre_cnt = '0;
    logic          go = 1'b0;
    logic          cap_stb, start_evt, stop_evt, active, done, err_early;
    logic [W-1:0]  cap_data;

    always #5 clk = ~clk;

    chgdet_trig #(.W(W), .CNT_W(CW)) uut (.*);

    typedef struct {
        logic [W-1:0] d;
        int           due;
        string        tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0, errors = 0;
    int   n_cap = 0, n_start = 0, n_stop = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected captures and compares word and cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_evt) n_start++;
            if (stop_evt)  n_stop++;
            if (cap_stb) begin
                n_cap++;
                if (q.size() == 0) begin
                    chk(1'b0, "R2/R4 unexpected capture", cap_data, '0);
                end else begin
                    e = q.pop_front();
                    chk(cap_data == e.d, e.tag, cap_data, e.d);
                    chk(cyc == e.due, {e.tag, " latency R1"}, cyc, e.due);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: applies a port value and queues the expected capture
    task automatic drive(logic [W-1:0] v, bit expect_cap, string tag);
        exp_t x;
        @(negedge clk);
        port_in = v;
        if (expect_cap) begin
            x.d = v; x.due = cyc + 3; x.tag = tag;
            q.push_back(x);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R13 watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, c0;
        step(3);
        rst_n = 1'b1;
        step(4);
        chk({cap_stb, active, done, err_early, start_evt, stop_evt} == 6'b0, "R13 reset outputs",
            {cap_stb, active, done, err_early, start_evt, stop_evt}, 0);
        chk(cap_data == '0, "R13 reset cap_data", cap_data, '0);

        // idle change: no capture
        drive(32'h0000_00FF, 1'b0, "R4 idle");
        step(4);
        chk(n_cap == 0, "R4 no capture in IDLE", n_cap, 0);

        // immediate start, never stop
        @(negedge clk); go = 1'b1;
        step(5);
        chk(active == 1'b1, "R5 immediate start active", active, 1);
        chk(n_start == 1, "R5 start_evt count", n_start, 1);
        drive(32'h1234_00F0, 1'b1, "R1/R3 masked change with unmasked bits");
        step(4);
        drive(32'hABCD_00F0, 1'b0, "R2");
        step(4);
        chk(n_cap == 1, "R2 unmasked change ignored", n_cap, 1);
        drive(32'hABCD_8000, 1'b1, "R1 multi-bit change");
        step(4);
        chk(n_cap == 2, "R1 capture count", n_cap, 2);
        @(negedge clk); go = 1'b0;
        step(2);
        chk(active == 1'b0, "R12 go low leaves RUN", active, 0);

        // edge start/stop, pre_cnt 2, early stop -> FAULT
        start_sel = 2'd1; stop_sel = 2'd1; pre_cnt = 16'd2;
        @(negedge clk); go = 1'b1;
        step(4);
        s0 = n_stop;
        stop_pin = 1'b1; step(4); stop_pin = 1'b0; step(4);
        chk(n_stop == s0, "R9 stop before start ignored", n_stop, s0);
        chk({done, err_early, active} == 3'b0, "R9 state unchanged", {done, err_early, active}, 0);
        drive(32'hABCD_0001, 1'b0, "R4 armed");
        step(4);
        chk(n_cap == 2, "R4 no capture in ARMED", n_cap, 2);
        @(negedge clk); start_pin = 1'b1;
        drive(32'hABCD_0003, 1'b0, "R8 sync clock");
        drive(32'hABCD_0007, 1'b1, "R8 first capture after SYNC");
        step(4);
        chk(n_cap == 3, "R8 only post-SYNC change captured", n_cap, 3);
        chk(n_start == 2 && active, "R5 rising edge start", n_start, 2);
        @(negedge clk); stop_pin = 1'b1;
        step(5);
        chk(err_early == 1'b1, "R11 early stop faults", err_early, 1);
        chk(done == 1'b0 && active == 1'b0, "R11 not done", {done, active}, 0);
        chk(n_stop == s0 + 1, "R11 stop_evt", n_stop, s0 + 1);
        @(negedge clk); go = 1'b0;
        step(2);
        chk(err_early == 1'b0, "R12 go low clears fault", err_early, 0);
        start_pin = 1'b0; stop_pin = 1'b0;
        step(4);

        // falling start, enough captures -> DONE
        start_pin = 1'b1; start_fall = 1'b1;
        step(4);
        @(negedge clk); go = 1'b1;
        step(4);
        chk(active == 1'b0, "R5 no start without falling edge", active, 0);
        @(negedge clk); start_pin = 1'b0;
        step(6);
        chk(active == 1'b1, "R5 falling edge start", active, 1);
        drive(32'hABCD_0107, 1'b1, "R1 capture 1 of 2");
        step(4);
        drive(32'hABCD_0106, 1'b1, "R1 capture 2 of 2");
        step(4);
        @(negedge clk); stop_pin = 1'b1;
        step(5);
        chk(done == 1'b1 && err_early == 1'b0 && active == 1'b0, "R10 stop enters DONE",
            {done, err_early, active}, 3'b100);
        c0 = n_cap;
        drive(32'hABCD_0000, 1'b0, "R10 after done");
        step(4);
        chk(n_cap == c0, "R10 no capture after DONE", n_cap, c0);
        @(negedge clk); go = 1'b0; stop_pin = 1'b0; start_fall = 1'b0;
        step(4);
        chk(done == 1'b0, "R12 go low clears done", done, 0);

        // pattern start on match, pattern stop
        sig_mask = 32'h0000_00FF; cmp_pat = 32'h0000_005A; pat_on_miss = 1'b0;
        start_sel = 2'd2; stop_sel = 2'd2; pre_cnt = '0;
        step(4);
        @(negedge clk); go = 1'b1;
        step(4);
        s0 = n_start;
        drive(32'h1111_005A, 1'b0, "R6 match start");
        step(5);
        chk(active == 1'b1 && n_start == s0 + 1, "R6 start on masked match", active, 1);
        drive(32'h2222_005A, 1'b0, "R7 hold");
        step(8);
        chk(active == 1'b1 && done == 1'b0, "R7 held condition does not stop", {active, done}, 2'b10);
        drive(32'h2222_00A5, 1'b1, "R7 leave match");
        step(4);
        chk(active == 1'b1, "R7 leaving match no event", active, 1);
        drive(32'h2222_005A, 1'b1, "R7 re-enter match");
        step(4);
        chk(done == 1'b1, "R7 re-entry fires stop", done, 1);
        @(negedge clk); go = 1'b0;
        step(2);

        // pattern start on mismatch; unmasked bits ignored
        pat_on_miss = 1'b1; stop_sel = 2'd3;
        step(4);
        @(negedge clk); go = 1'b1;
        step(4);
        drive(32'h9999_005A, 1'b0, "R6 unmasked");
        step(5);
        chk(active == 1'b0, "R6 unmasked bits not compared", active, 0);
        drive(32'h9999_005B, 1'b0, "R6 mismatch start");
        step(5);
        chk(active == 1'b1, "R6 start on masked mismatch", active, 1);
        @(negedge clk); go = 1'b0;
        step(6);

        chk(q.size() == 0, "R1 all expected captures seen", q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule